// File: doc/BRIEF.md
# Past-Time Temporal Property Checker

This block watches a stream of boolean events and decides, at every evaluation step, whether a fixed past-time temporal property still holds. A step occurs on each clock cycle in which the step strobe is high; on other cycles every input is ignored and all state holds. The main property is "whenever grant is seen, request must have been seen at this step or at some step before it". It needs one bit of memory, which records whether request has appeared since reset. After each step the block presents a registered verdict. When the verdict is false, it also raises a one-cycle violation pulse that a recovery handler can react to.

All memory bits are updated in parallel on the same edge. The verdict therefore cannot read a memory bit's old register value. It uses that bit's next-state expression, so an event that arrives in the current step counts at once. The same rule applies to four reusable operator blocks, which are also brought out at the ports and driven by two generic operand events A and B:

- **previous step**: A was true at the previous step.
- **ever in the past**: A was true at some step.
- **always in the past**: A was true at every step.
- **since**: A has held at every step after the most recent step at which B was true.

Top module: `ptl_monitor`

## Requirements
- R1: A synchronous reset sets verdict_o to 1, violation_o to 0, prev_o to 0, once_o to 0, hist_o to 1 and since_o to 0, and clears the record of past requests.
- R2: On a cycle where step_i is 0, every output except violation_o keeps its value, and grant_i, request_i, a_i and b_i have no effect.
- R3: After each step, verdict_o equals (NOT grant_i) OR (request_i was 1 at this step or at any earlier step since reset).
- R4: A request in the same step as a grant satisfies that grant, including on the very first step after reset.
- R5: violation_o is 1 for exactly the one cycle that follows a step whose verdict is 0, and is 0 otherwise.
- R6: After each step, prev_o equals the value a_i had at the preceding step, and is 0 after the first step following reset.
- R7: After each step, once_o is 1 if a_i was 1 at this step or at any earlier step since reset.
- R8: After each step, hist_o is 1 only if a_i was 1 at this step and at every earlier step since reset.
- R9: After each step, since_o is 1 if b_i is 1 at this step. Otherwise it is a_i AND the value since_o held before this step.
- R10: Each output reflects a step in the cycle right after the clock edge that samples that step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| step_i | input | 1 | Evaluation step strobe |
| grant_i | input | 1 | Grant event of the main property |
| request_i | input | 1 | Request event of the main property |
| a_i | input | 1 | Operand A of the operator blocks |
| b_i | input | 1 | Operand B of the since operator |
| verdict_o | output | 1 | Main property holds after the last step |
| violation_o | output | 1 | One-cycle pulse after a failing step |
| prev_o | output | 1 | Previous-step value of A |
| once_o | output | 1 | A seen at some step |
| hist_o | output | 1 | A seen at every step |
| since_o | output | 1 | A since B |

## Verification
Each memory bit feeds one output directly, so a wrong bit shows up at the ports in the cycle after the first step whose result depends on it.

- A request record that fails to set shows up as a false violation on the next grant-only step.
- A memory bit read as its stale register value, instead of its next-state value, shows up on the first step where the event arrives together with the grant.
- An update that happens without the step strobe changes an output on a non-step cycle one cycle later.

The bench mixes directed steps for these coincidences with long random runs that include periodic resets.

// File: rtl/ptl_pkg.sv
package ptl_pkg;

    typedef enum logic [1:0] {
        OP_PREV,
        OP_ONCE,
        OP_HIST
    } ptl_unary_e;

    typedef struct packed {
        logic state;
        logic held;
    } ptl_op_regs_t;

    typedef struct packed {
        logic req_seen;
        logic verdict;
        logic viol;
    } ptl_top_regs_t;

endpackage

// File: rtl/ptl_unary.sv
module ptl_unary
    import ptl_pkg::*;
#(
    parameter ptl_unary_e OP = OP_ONCE
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic step_i,
    input  logic a_i,
    output logic held_o
);

    // Empty history: "always" is vacuously true, the others are false.
    localparam logic INIT = (OP == OP_HIST) ? 1'b1 : 1'b0;

    ptl_op_regs_t r_q, r_d;
    logic now_w;      // operator value including this step
    logic nxt_w;      // next state bit

    generate
        if (OP == OP_PREV) begin : g_prev
            assign now_w = r_q.state;
            assign nxt_w = a_i;
        end else if (OP == OP_ONCE) begin : g_once
            assign now_w = a_i | r_q.state;
            assign nxt_w = now_w;
        end else begin : g_hist
            assign now_w = a_i & r_q.state;
            assign nxt_w = now_w;
        end
    endgenerate

    always_comb begin
        r_d = r_q;
        if (rst_i) begin
            r_d.state = INIT;
            r_d.held  = INIT;
        end else if (step_i) begin
            r_d.state = nxt_w;
            r_d.held  = now_w;
        end
    end

    always_ff @(posedge clk_i) begin
        r_q <= r_d;
    end

    assign held_o = r_q.held;

    AST_OP_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
        !step_i |=> $stable(held_o)); // R2

    generate
        if (OP == OP_PREV) begin : g_ast_prev
            AST_PREV_FOLLOWS: assert property (@(posedge clk_i) disable iff (rst_i)
                step_i ##1 step_i |=> held_o == $past(a_i, 2)); // R6
        end else if (OP == OP_ONCE) begin : g_ast_once
            AST_ONCE_SETS: assert property (@(posedge clk_i) disable iff (rst_i)
                step_i && a_i |=> held_o); // R7
            AST_ONCE_STICKS: assert property (@(posedge clk_i) disable iff (rst_i)
                held_o |=> held_o); // R7
        end else begin : g_ast_hist
            AST_HIST_CLEARS: assert property (@(posedge clk_i) disable iff (rst_i)
                step_i && !a_i |=> !held_o); // R8
            AST_HIST_STICKS: assert property (@(posedge clk_i) disable iff (rst_i)
                !held_o |=> !held_o); // R8
        end
    endgenerate

endmodule

// File: rtl/ptl_since.sv
module ptl_since
    import ptl_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic step_i,
    input  logic a_i,
    input  logic b_i,
    output logic held_o
);

    ptl_op_regs_t r_q, r_d;
    logic now_w;

    // Value including this step: B now, or A now and held before.
    assign now_w = b_i | (a_i & r_q.state);

    always_comb begin
        r_d = r_q;
        if (rst_i) begin
            r_d.state = 1'b0;
            r_d.held  = 1'b0;
        end else if (step_i) begin
            r_d.state = now_w;
            r_d.held  = now_w;
        end
    end

    always_ff @(posedge clk_i) begin
        r_q <= r_d;
    end

    assign held_o = r_q.held;

    AST_SINCE_ANCHOR: assert property (@(posedge clk_i) disable iff (rst_i)
        step_i && b_i |=> held_o); // R9
    AST_SINCE_BREAK: assert property (@(posedge clk_i) disable iff (rst_i)
        step_i && !a_i && !b_i |=> !held_o); // R9
    AST_SINCE_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
        !step_i |=> $stable(held_o)); // R2

endmodule

// File: rtl/ptl_monitor.sv
module ptl_monitor
    import ptl_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic step_i,
    input  logic grant_i,
    input  logic request_i,
    input  logic a_i,
    input  logic b_i,
    output logic verdict_o,
    output logic violation_o,
    output logic prev_o,
    output logic once_o,
    output logic hist_o,
    output logic since_o
);

    ptl_top_regs_t r_q, r_d;
    logic seen_nxt_w;
    logic verdict_w;

    // Parallel update: the verdict reads the request record's next value.
    assign seen_nxt_w = request_i | r_q.req_seen;
    assign verdict_w  = ~grant_i | seen_nxt_w;

    always_comb begin
        r_d      = r_q;
        r_d.viol = 1'b0;
        if (rst_i) begin
            r_d.req_seen = 1'b0;
            r_d.verdict  = 1'b1;
        end else if (step_i) begin
            r_d.req_seen = seen_nxt_w;
            r_d.verdict  = verdict_w;
            r_d.viol     = ~verdict_w;
        end
    end

    always_ff @(posedge clk_i) begin
        r_q <= r_d;
    end

    assign verdict_o   = r_q.verdict;
    assign violation_o = r_q.viol;

    ptl_unary #(.OP(OP_PREV)) u_prev (
        .clk_i (clk_i), .rst_i (rst_i), .step_i (step_i), .a_i (a_i), .held_o (prev_o)
    );

    ptl_unary #(.OP(OP_ONCE)) u_once (
        .clk_i (clk_i), .rst_i (rst_i), .step_i (step_i), .a_i (a_i), .held_o (once_o)
    );

    ptl_unary #(.OP(OP_HIST)) u_hist (
        .clk_i (clk_i), .rst_i (rst_i), .step_i (step_i), .a_i (a_i), .held_o (hist_o)
    );

    ptl_since u_since (
        .clk_i (clk_i), .rst_i (rst_i), .step_i (step_i),
        .a_i (a_i), .b_i (b_i), .held_o (since_o)
    );

    AST_VIOL_NEEDS_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
        !step_i |=> !violation_o); // R5
    AST_VIOL_LOW_VERDICT: assert property (@(posedge clk_i) disable iff (rst_i)
        violation_o |-> !verdict_o); // R5
    AST_VERDICT_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
        !step_i |=> $stable(verdict_o)); // R2
    AST_REQ_SAME_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
        step_i && request_i |=> verdict_o); // R4
    AST_NO_GRANT_PASS: assert property (@(posedge clk_i) disable iff (rst_i)
        step_i && !grant_i |=> verdict_o); // R3

endmodule

// File: tb/ptl_monitor_bench.sv
module ptl_monitor_bench;

    logic clk = 1'b0;
    logic rst, step, grant, request, a, b;
    logic verdict, violation, prev, once, hist, since;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    // reference model state
    bit m_seen, m_verdict, m_viol, m_alast, m_prev, m_once, m_hist, m_since;

    always #5 clk = ~clk;

    ptl_monitor u_ptl_monitor (
        .clk_i (clk), .rst_i (rst), .step_i (step), .grant_i (grant),
        .request_i (request), .a_i (a), .b_i (b),
        .verdict_o (verdict), .violation_o (violation),
        .prev_o (prev), .once_o (once), .hist_o (hist), .since_o (since)
    );

    task automatic check(input string tag, input logic act, input bit exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
        end
    endtask

    function automatic bit exp_verdict(bit g, bit r, bit seen);
        return !g || r || seen;
    endfunction

    task automatic compare_all();
        check("R3 verdict", verdict, m_verdict);
        check("R5 violation", violation, m_viol);
        check("R6 prev", prev, m_prev);
        check("R7 once", once, m_once);
        check("R8 hist", hist, m_hist);
        check("R9 since", since, m_since);
    endtask

    task automatic cycle(input bit r_, input bit s_, input bit g_, input bit q_,
                         input bit a_, input bit b_);
        rst = r_; step = s_; grant = g_; request = q_; a = a_; b = b_;
        @(posedge clk);
        if (r_) begin
            m_seen = 0; m_verdict = 1; m_viol = 0; m_alast = 0;
            m_prev = 0; m_once = 0; m_hist = 1; m_since = 0;
        end else if (s_) begin
            m_verdict = exp_verdict(g_, q_, m_seen);
            m_viol    = !m_verdict;
            m_seen    = m_seen | q_;
            m_prev    = m_alast;
            m_alast   = a_;
            m_once    = m_once | a_;
            m_hist    = m_hist & a_;
            m_since   = b_ | (a_ & m_since);
        end else begin
            m_viol = 0;
        end
        @(negedge clk);   // R10: result visible in the cycle after the edge
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rst = 1; step = 0; grant = 0; request = 0; a = 0; b = 0;
        @(negedge clk);

        // R1: reset state
        cycle(1, 1, 1, 0, 1, 1);
        cycle(1, 0, 0, 0, 0, 0);
        check("R1 verdict", verdict, 1'b1);
        check("R1 violation", violation, 1'b0);
        check("R1 prev", prev, 1'b0);
        check("R1 once", once, 1'b0);
        check("R1 hist", hist, 1'b1);
        check("R1 since", since, 1'b0);

        // R4: same-step request satisfies grant on first step
        cycle(0, 1, 1, 1, 1, 0);
        check("R4 same-step request", verdict, 1'b1);
        check("R4 no violation", violation, 1'b0);
        check("R6 first step prev", prev, 1'b0);
        compare_all();

        // R3/R5: grant without any request fails, pulse lasts one cycle
        cycle(1, 0, 0, 0, 0, 0);
        cycle(0, 1, 1, 0, 0, 1);
        check("R3 grant w/o request", verdict, 1'b0);
        check("R5 pulse", violation, 1'b1);
        compare_all();
        cycle(0, 0, 1, 0, 0, 0);
        check("R5 pulse ends", violation, 1'b0);
        check("R2 verdict held", verdict, 1'b0);

        // R2: non-step cycles ignore every event
        for (int i = 0; i < 6; i++) begin
            cycle(0, 0, i[0], 1, i[1], i[0]);
            check("R2 verdict", verdict, 1'b0);
            check("R2 once", once, 1'b0);
            check("R2 since", since, 1'b1);
            check("R2 hist", hist, 1'b0);
        end

        // R3: later request then grant passes
        cycle(0, 1, 0, 1, 1, 0);
        cycle(0, 1, 1, 0, 1, 0);
        check("R3 past request", verdict, 1'b1);
        check("R6 prev of a", prev, 1'b1);
        compare_all();

        // random run with occasional resets
        for (int i = 0; i < 4000; i++) begin
            bit r_, s_, g_, q_, a_, b_;
            r_ = ($urandom % 48) == 0;
            s_ = ($urandom % 3) != 0;
            g_ = $urandom % 2;
            q_ = ($urandom % 10) == 0;
            a_ = ($urandom % 8) != 0;
            b_ = ($urandom % 6) == 0;
            cycle(r_, s_, g_, q_, a_, b_);
            compare_all();
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule